// File: doc/BRIEF.md
# Posted-Write Delayed-Read Bus Target

This block is the host-facing target for a memory window that reaches a slow 8- or 16-bit local bus. The host offers one request per cycle: an address, a 32-bit word, four byte enables and a direction. The target answers every request that falls in its window, one cycle later, with either a completion (`hs_ack`) or a retry (`hs_retry`). Requests outside the window get no answer.

Writes are posted. One word and its byte enables are captured, the host is acknowledged at once, and the word then drains to the local bus in the background. Reads are delayed. The first read is retried, and the local read is started and recorded in a single pending entry. Only a later request with the same word address and byte enables can collect the data. Because every answer comes back in the next cycle, the host data phase never stalls for long.

The local side is a request/done handshake towards a bus sequencer. The host word is split into lane groups of the local bus width, one handshake per group that has an enabled byte. The window is decoded from a base address input and a power-of-two size input.

Top module: `pwdr_target`

## Requirements
- R1: An in-window write, seen while the lane engine is idle and no delayed read is held or pending, is answered with `hs_ack` in the next cycle. Its word and byte enables are then written to the local bus, and the first local request rises one cycle after the ack.
- R2: While a posted write is still draining, every in-window request, write or read, is answered with `hs_retry`. A read refused this way leaves no pending entry and starts no local cycle.
- R3: An in-window read, seen while the target is idle, is answered with `hs_retry`, and the local read of its lanes is started.
- R4: Repeats with the same word address (bits 31:2) and the same byte enables get `hs_retry` until the local read has finished. The first matching repeat after that gets `hs_ack`.
- R5: While a delayed read is pending or held, a write, or a read that differs in word address or byte enables, gets `hs_retry`. The entry is left unchanged and no local cycle starts.
- R6: A request is in the window when the address bits at and above `win_log2` equal those of `win_base`. A request outside the window gets neither `hs_ack` nor `hs_retry` and starts no local cycle.
- R7: The host word is split into 32/LB_DW lane groups. Group g covers host bytes g*LB_DW/8 upward. The groups are issued in ascending order, and only groups that have an enabled byte are issued. Each group goes out at local address offset + g*LB_DW/8, where offset is the host address below `win_log2` with bits 1:0 cleared, and its byte enables become the strobes. A local request is held, with stable address and strobes, until `lb_done`.
- R8: On a read completion, host byte i (bits 8i+7:8i) carries the local byte read for it if enable bit i is set, and zero if it is not. `hs_lanes` equals the requested byte enables. A write completion returns zero data and zero lanes.
- R9: Delivering the read data frees the entry. The next read starts a new local read, even if it repeats the address just delivered.
- R10: Every in-window request gets exactly one of `hs_ack` and `hs_retry`, in the cycle after it was presented. The two are never high together.
- R11: With all byte enables clear, a write is acked and a read is retried and then completed with zero lanes. Neither issues a local cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_base | input | 32 | Window base address |
| win_log2 | input | 5 | Log2 of window size in bytes (2..LB_AW) |
| hq_valid | input | 1 | Host request present this cycle |
| hq_write | input | 1 | 1 = write, 0 = read |
| hq_addr | input | 32 | Host byte address |
| hq_be | input | 4 | Host byte enables, bit i for byte i |
| hq_wdata | input | 32 | Host write word |
| hs_ack | output | 1 | Request completed |
| hs_retry | output | 1 | Request must be retried |
| hs_rdata | output | 32 | Read data on completion |
| hs_lanes | output | 4 | Valid byte lanes of hs_rdata |
| lb_req | output | 1 | Local access request, held until done |
| lb_we | output | 1 | Local access is a write |
| lb_addr | output | LB_AW | Local byte address |
| lb_wdata | output | LB_DW | Local write data |
| lb_strb | output | LB_DW/8 | Local byte strobes |
| lb_done | input | 1 | Local access finished (one-cycle pulse) |
| lb_rdata | input | LB_DW | Local read data, valid with lb_done |

## Verification
The bench sweeps all sixteen byte-enable patterns through both the write and the delayed-read paths. The write sweep shows whether lane groups are skipped, ordered and strobed correctly. The read sweep shows whether each byte lands on its own host lane or is zeroed. Within each read it sends a bare repeat, a repeat with one enable flipped, a repeat at the next word, and a write. These show whether matching uses both the address and the enables, and whether a pending entry blocks other traffic. Addresses just below, just above and far from the window, tried at two window sizes, show whether the decode honours the size input.

// File: rtl/pwdr_pkg.sv
package pwdr_pkg;
  localparam int HOST_DW = 32;
  localparam int HOST_BE = HOST_DW / 8;

  typedef enum logic [1:0] {
    RD_FREE = 2'd0,
    RD_WAIT = 2'd1,
    RD_HELD = 2'd2
  } rd_state_e;

  typedef struct packed {
    logic               we;
    logic [HOST_DW-1:0] off;
    logic [HOST_BE-1:0] be;
    logic [HOST_DW-1:0] wdata;
  } job_t;
endpackage

// File: rtl/pwdr_win_dec.sv
module pwdr_win_dec
  import pwdr_pkg::*;
(
  input  logic [HOST_DW-1:0] base_i,
  input  logic [4:0]         log2_i,
  input  logic [HOST_DW-1:0] addr_i,
  output logic               hit_o,
  output logic [HOST_DW-1:0] off_o
);
  logic [HOST_DW-1:0] mask_lo;

  always_comb begin
    mask_lo = (HOST_DW'(1) << log2_i) - HOST_DW'(1);
    hit_o   = ((addr_i ^ base_i) & ~mask_lo) == '0;
    off_o   = addr_i & mask_lo & ~HOST_DW'(HOST_BE - 1);
  end
endmodule

// File: rtl/pwdr_lane_eng.sv
module pwdr_lane_eng
  import pwdr_pkg::*;
#(
  parameter int LB_DW = 16,
  parameter int LB_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  job_t               job_i,
  output logic               busy_o,
  output logic               fin_o,
  output logic [HOST_DW-1:0] rdata_o,
  output logic               lb_req_o,
  output logic               lb_we_o,
  output logic [LB_AW-1:0]   lb_addr_o,
  output logic [LB_DW-1:0]   lb_wdata_o,
  output logic [LB_DW/8-1:0] lb_strb_o,
  input  logic               lb_done_i,
  input  logic [LB_DW-1:0]   lb_rdata_i
);
  localparam int LBB    = LB_DW / 8;
  localparam int GROUPS = HOST_DW / LB_DW;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  job_t              job_q;
  logic [GROUPS-1:0] pend_q;
  logic [GROUPS-1:0] grp_en;
  logic [GW-1:0]     nxt_g;
  logic [GW-1:0]     cur_q;
  logic [LB_AW-1:0]  base_off;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_en[g] = |job_i.be[g*LBB +: LBB];
  end

  always_comb begin
    nxt_g = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (pend_q[g]) nxt_g = GW'(g);
    end
  end

  assign base_off = job_q.off[LB_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      job_q      <= '0;
      pend_q     <= '0;
      cur_q      <= '0;
      busy_o     <= 1'b0;
      fin_o      <= 1'b0;
      rdata_o    <= '0;
      lb_req_o   <= 1'b0;
      lb_we_o    <= 1'b0;
      lb_addr_o  <= '0;
      lb_wdata_o <= '0;
      lb_strb_o  <= '0;
    end else begin
      fin_o <= 1'b0;
      if (start_i) begin
        job_q    <= job_i;
        pend_q   <= grp_en;
        busy_o   <= 1'b1;
        lb_req_o <= 1'b0;
        rdata_o  <= '0;
      end else if (busy_o) begin
        if (lb_req_o) begin
          if (lb_done_i) begin
            lb_req_o <= 1'b0;
            if (!job_q.we) begin
              for (int b = 0; b < LBB; b++) begin
                rdata_o[(int'(cur_q)*LBB + b)*8 +: 8] <=
                  lb_strb_o[b] ? lb_rdata_i[b*8 +: 8] : 8'h00;
              end
            end
          end
        end else if (|pend_q) begin
          lb_req_o      <= 1'b1;
          lb_we_o       <= job_q.we;
          lb_addr_o     <= base_off + LB_AW'(int'(nxt_g) * LBB);
          lb_wdata_o    <= job_q.wdata[int'(nxt_g)*LB_DW +: LB_DW];
          lb_strb_o     <= job_q.be[int'(nxt_g)*LBB +: LBB];
          pend_q[nxt_g] <= 1'b0;
          cur_q         <= nxt_g;
        end else begin
          busy_o <= 1'b0;
          fin_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwdr_txn_ctl.sv
module pwdr_txn_ctl
  import pwdr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               hq_valid,
  input  logic               hq_write,
  input  logic [HOST_DW-1:0] hq_addr,
  input  logic [HOST_BE-1:0] hq_be,
  input  logic [HOST_DW-1:0] hq_wdata,
  input  logic               hit_i,
  input  logic [HOST_DW-1:0] off_i,
  input  logic               eng_busy_i,
  input  logic               eng_fin_i,
  input  logic [HOST_DW-1:0] eng_rdata_i,
  output logic               start_o,
  output job_t               job_o,
  output logic               hs_ack,
  output logic               hs_retry,
  output logic [HOST_DW-1:0] hs_rdata,
  output logic [HOST_BE-1:0] hs_lanes
);
  rd_state_e          rd_st;
  logic [HOST_DW-3:0] rd_word;
  logic [HOST_BE-1:0] rd_be;
  logic [HOST_DW-1:0] rd_data;
  logic               is_match;
  logic               ack_n;
  logic               retry_n;
  logic               take;
  logic               give;

  assign is_match = (rd_word == hq_addr[HOST_DW-1:2]) && (rd_be == hq_be);

  always_comb begin
    start_o = 1'b0;
    ack_n   = 1'b0;
    retry_n = 1'b0;
    take    = 1'b0;
    give    = 1'b0;
    job_o   = '{we: hq_write, off: off_i, be: hq_be, wdata: hq_wdata};
    if (hq_valid && hit_i) begin
      if (hq_write) begin
        if (!eng_busy_i && rd_st == RD_FREE) begin
          ack_n   = 1'b1;
          start_o = 1'b1;
        end else begin
          retry_n = 1'b1;
        end
      end else begin
        case (rd_st)
          RD_FREE: begin
            retry_n = 1'b1;
            if (!eng_busy_i) begin
              start_o = 1'b1;
              take    = 1'b1;
            end
          end
          RD_HELD: begin
            if (is_match) begin
              ack_n = 1'b1;
              give  = 1'b1;
            end else begin
              retry_n = 1'b1;
            end
          end
          default: retry_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_st    <= RD_FREE;
      rd_word  <= '0;
      rd_be    <= '0;
      rd_data  <= '0;
      hs_ack   <= 1'b0;
      hs_retry <= 1'b0;
      hs_rdata <= '0;
      hs_lanes <= '0;
    end else begin
      hs_ack   <= ack_n;
      hs_retry <= retry_n;
      hs_rdata <= give ? rd_data : '0;
      hs_lanes <= give ? rd_be : '0;
      if (take) begin
        rd_st   <= RD_WAIT;
        rd_word <= hq_addr[HOST_DW-1:2];
        rd_be   <= hq_be;
      end else if (rd_st == RD_WAIT && eng_fin_i) begin
        rd_st   <= RD_HELD;
        rd_data <= eng_rdata_i;
      end else if (give) begin
        rd_st <= RD_FREE;
      end
    end
  end
endmodule

// File: rtl/pwdr_target.sv
module pwdr_target
  import pwdr_pkg::*;
#(
  parameter int LB_DW = 16,
  parameter int LB_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        win_base,
  input  logic [4:0]         win_log2,
  input  logic               hq_valid,
  input  logic               hq_write,
  input  logic [31:0]        hq_addr,
  input  logic [3:0]         hq_be,
  input  logic [31:0]        hq_wdata,
  output logic               hs_ack,
  output logic               hs_retry,
  output logic [31:0]        hs_rdata,
  output logic [3:0]         hs_lanes,
  output logic               lb_req,
  output logic               lb_we,
  output logic [LB_AW-1:0]   lb_addr,
  output logic [LB_DW-1:0]   lb_wdata,
  output logic [LB_DW/8-1:0] lb_strb,
  input  logic               lb_done,
  input  logic [LB_DW-1:0]   lb_rdata
);
  logic               hit;
  logic [HOST_DW-1:0] off;
  logic               start;
  job_t               job;
  logic               eng_busy;
  logic               eng_fin;
  logic [HOST_DW-1:0] eng_rdata;

  pwdr_win_dec u_dec (
    .base_i (win_base),
    .log2_i (win_log2),
    .addr_i (hq_addr),
    .hit_o  (hit),
    .off_o  (off)
  );

  pwdr_txn_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .hq_valid    (hq_valid),
    .hq_write    (hq_write),
    .hq_addr     (hq_addr),
    .hq_be       (hq_be),
    .hq_wdata    (hq_wdata),
    .hit_i       (hit),
    .off_i       (off),
    .eng_busy_i  (eng_busy),
    .eng_fin_i   (eng_fin),
    .eng_rdata_i (eng_rdata),
    .start_o     (start),
    .job_o       (job),
    .hs_ack      (hs_ack),
    .hs_retry    (hs_retry),
    .hs_rdata    (hs_rdata),
    .hs_lanes    (hs_lanes)
  );

  pwdr_lane_eng #(.LB_DW(LB_DW), .LB_AW(LB_AW)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .job_i      (job),
    .busy_o     (eng_busy),
    .fin_o      (eng_fin),
    .rdata_o    (eng_rdata),
    .lb_req_o   (lb_req),
    .lb_we_o    (lb_we),
    .lb_addr_o  (lb_addr),
    .lb_wdata_o (lb_wdata),
    .lb_strb_o  (lb_strb),
    .lb_done_i  (lb_done),
    .lb_rdata_i (lb_rdata)
  );
endmodule

// File: rtl/pwdr_target_chk.sv
module pwdr_target_chk #(
  parameter int LB_DW = 16,
  parameter int LB_AW = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [31:0]        win_base,
  input logic [4:0]         win_log2,
  input logic               hq_valid,
  input logic               hq_write,
  input logic [31:0]        hq_addr,
  input logic [3:0]         hq_be,
  input logic               hs_ack,
  input logic               hs_retry,
  input logic [31:0]        hs_rdata,
  input logic [3:0]         hs_lanes,
  input logic               lb_req,
  input logic               lb_we,
  input logic [LB_AW-1:0]   lb_addr,
  input logic [LB_DW/8-1:0] lb_strb,
  input logic               lb_done
);
  logic        in_win;
  logic [31:0] lane_bits;

  assign in_win = ((hq_addr ^ win_base) >> win_log2) == 32'h0;

  always_comb begin
    for (int i = 0; i < 4; i++) lane_bits[i*8 +: 8] = {8{hs_lanes[i]}};
  end

  // R10
  resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_ack && hs_retry));

  // R10
  resp_given_chk: assert property (@(posedge clk) disable iff (rst)
    hq_valid && in_win |=> hs_ack || hs_retry);

  // R6
  miss_silent_chk: assert property (@(posedge clk) disable iff (rst)
    hq_valid && !in_win |=> !hs_ack && !hs_retry);

  // R7
  lb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lb_req && !lb_done |=> lb_req && $stable(lb_addr) && $stable(lb_strb));

  // R8
  lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hs_ack |-> (hs_rdata & ~lane_bits) == 32'h0);

  // R1
  post_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (hq_valid && in_win && hq_write && hq_be != 4'h0) ##1 hs_ack |=> lb_req && lb_we);
endmodule

bind pwdr_target pwdr_target_chk #(.LB_DW(LB_DW), .LB_AW(LB_AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .win_base (win_base),
  .win_log2 (win_log2),
  .hq_valid (hq_valid),
  .hq_write (hq_write),
  .hq_addr  (hq_addr),
  .hq_be    (hq_be),
  .hs_ack   (hs_ack),
  .hs_retry (hs_retry),
  .hs_rdata (hs_rdata),
  .hs_lanes (hs_lanes),
  .lb_req   (lb_req),
  .lb_we    (lb_we),
  .lb_addr  (lb_addr),
  .lb_strb  (lb_strb),
  .lb_done  (lb_done)
);

// File: tb/pwdr_target_test.sv
module pwdr_target_test;
  localparam int LB_DW = 16;
  localparam int LB_AW = 16;
  localparam int WAITS = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] win_base = 32'h4000_0000;
  logic [4:0]  win_log2 = 5'd8;
  logic        hq_valid = 1'b0;
  logic        hq_write = 1'b0;
  logic [31:0] hq_addr = '0;
  logic [3:0]  hq_be = '0;
  logic [31:0] hq_wdata = '0;
  logic        hs_ack, hs_retry;
  logic [31:0] hs_rdata;
  logic [3:0]  hs_lanes;
  logic        lb_req, lb_we;
  logic [LB_AW-1:0] lb_addr;
  logic [LB_DW-1:0] lb_wdata;
  logic [1:0]  lb_strb;
  logic        lb_done = 1'b0;
  logic [LB_DW-1:0] lb_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        r_ack, r_retry;
  logic [31:0] r_rdata;
  logic [3:0]  r_lanes;

  int          wcnt = 0;
  int          log_n = 0;
  logic [15:0] log_addr [0:511];
  logic [1:0]  log_strb [0:511];
  logic [15:0] log_data [0:511];
  logic        log_we   [0:511];

  always #4 clk = ~clk;

  pwdr_target #(.LB_DW(LB_DW), .LB_AW(LB_AW)) uut (
    .clk(clk), .rst(rst), .win_base(win_base), .win_log2(win_log2),
    .hq_valid(hq_valid), .hq_write(hq_write), .hq_addr(hq_addr),
    .hq_be(hq_be), .hq_wdata(hq_wdata),
    .hs_ack(hs_ack), .hs_retry(hs_retry), .hs_rdata(hs_rdata), .hs_lanes(hs_lanes),
    .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_strb(lb_strb), .lb_done(lb_done), .lb_rdata(lb_rdata)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // local bus sequencer model: done after WAITS cycles, logs each access
  always @(posedge clk) begin
    if (rst) begin
      lb_done <= 1'b0;
      wcnt    <= 0;
    end else if (lb_done) begin
      lb_done <= 1'b0;
      wcnt    <= 0;
    end else if (lb_req) begin
      if (wcnt == WAITS) begin
        lb_done  <= 1'b1;
        lb_rdata <= {pat(lb_addr + 16'd1), pat(lb_addr)};
        log_addr[log_n & 511] <= lb_addr;
        log_strb[log_n & 511] <= lb_strb;
        log_data[log_n & 511] <= lb_wdata;
        log_we[log_n & 511]   <= lb_we;
        log_n <= log_n + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic w, input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hq_valid = 1'b1; hq_write = w; hq_addr = a; hq_be = be; hq_wdata = d;
    @(negedge clk);
    hq_valid = 1'b0;
    r_ack = hs_ack; r_retry = hs_retry; r_rdata = hs_rdata; r_lanes = hs_lanes;
    // R10: never both
    chk(!(r_ack && r_retry), "R10 exclusive", {30'd0, r_ack, r_retry}, 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int groups(input logic [3:0] be);
    return int'(|be[1:0]) + int'(|be[3:2]);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] off, input logic [3:0] be);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[i*8 +: 8] = pat(16'(off + 32'(i)));
    return r;
  endfunction

  // check the local entries from index b0 against a host word
  task automatic chk_log(input int b0, input logic w, input logic [31:0] off,
                         input logic [3:0] be, input logic [31:0] d, input string tag);
    int k = b0;
    chk(log_n - b0 == groups(be), {tag, " group count"}, 32'(log_n - b0), 32'(groups(be)));
    for (int g = 0; g < 2; g++) begin
      if (be[g*2 +: 2] != 2'b00) begin
        chk(log_addr[k & 511] == 16'(off + 32'(2*g)), {tag, " addr"},
            32'(log_addr[k & 511]), off + 32'(2*g));
        chk(log_strb[k & 511] == be[g*2 +: 2], {tag, " strb"},
            32'(log_strb[k & 511]), 32'(be[g*2 +: 2]));
        chk(log_we[k & 511] == w, {tag, " dir"}, 32'(log_we[k & 511]), 32'(w));
        if (w)
          chk(log_data[k & 511] == d[g*16 +: 16], {tag, " data"},
              32'(log_data[k & 511]), 32'(d[g*16 +: 16]));
        k++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b0;
    logic [31:0] a, off, d;
    logic [3:0] mbe;

    repeat (3) @(negedge clk);
    chk(!hs_ack && !hs_retry && !lb_req, "reset outputs quiet",
        {29'd0, hs_ack, hs_retry, lb_req}, 32'h0);
    rst = 1'b0;
    idle(2);

    // R1, R7, R11: write sweep over all byte-enable patterns
    for (int be = 0; be < 16; be++) begin
      off = 32'(be) << 2;
      a   = win_base + off;
      d   = 32'hA1B2_C3D4 ^ (32'(be) * 32'h0101_0101);
      b0  = log_n;
      req(1'b1, a, 4'(be), d);
      chk(r_ack && !r_retry, "R1 write acked", {30'd0, r_ack, r_retry}, 32'h2);
      idle(20);
      chk_log(b0, 1'b1, off, 4'(be), d, be == 0 ? "R11 write lanes" : "R7 write lanes");
    end

    // R2: requests during a posted write drain
    b0 = log_n;
    req(1'b1, win_base + 32'h80, 4'hF, 32'h1122_3344);
    chk(r_ack, "R1 first write", {31'd0, r_ack}, 32'h1);
    req(1'b1, win_base + 32'h84, 4'hF, 32'h5566_7788);
    chk(r_retry && !r_ack, "R2 second write retried", {30'd0, r_ack, r_retry}, 32'h1);
    req(1'b0, win_base + 32'h90, 4'hF, 32'h0);
    chk(r_retry && !r_ack, "R2 read retried during drain", {30'd0, r_ack, r_retry}, 32'h1);
    idle(20);
    chk_log(b0, 1'b1, 32'h80, 4'hF, 32'h1122_3344, "R2 only first write drained");
    b0 = log_n;
    req(1'b0, win_base + 32'h90, 4'hF, 32'h0);
    chk(r_retry, "R2 refused read not latched", {31'd0, r_retry}, 32'h1);
    idle(20);
    chk_log(b0, 1'b0, 32'h90, 4'hF, 32'h0, "R3 read after drain");
    req(1'b0, win_base + 32'h90, 4'hF, 32'h0);
    chk(r_ack && r_rdata == exp_rd(32'h90, 4'hF), "R4 read collected", r_rdata, exp_rd(32'h90, 4'hF));

    // R3, R4, R5, R8, R11: read sweep
    for (int be = 0; be < 16; be++) begin
      off = 32'h40 + (32'(be) << 2);
      a   = win_base + off;
      mbe = 4'(be) ^ 4'h1;
      b0  = log_n;
      req(1'b0, a, 4'(be), 32'h0);
      chk(r_retry && !r_ack, "R3 first read retried", {30'd0, r_ack, r_retry}, 32'h1);
      req(1'b0, a, 4'(be), 32'h0);
      chk(r_retry && !r_ack, "R4 repeat while pending", {30'd0, r_ack, r_retry}, 32'h1);
      idle(20);
      chk_log(b0, 1'b0, off, 4'(be), 32'h0, be == 0 ? "R11 read lanes" : "R7 read lanes");
      b0 = log_n;
      req(1'b0, a, mbe, 32'h0);
      chk(r_retry && !r_ack, "R5 other enables retried", {30'd0, r_ack, r_retry}, 32'h1);
      req(1'b0, a + 32'h4, 4'(be), 32'h0);
      chk(r_retry && !r_ack, "R5 other address retried", {30'd0, r_ack, r_retry}, 32'h1);
      req(1'b1, a, 4'hF, 32'hDEAD_BEEF);
      chk(r_retry && !r_ack, "R5 write retried", {30'd0, r_ack, r_retry}, 32'h1);
      idle(6);
      chk(log_n == b0, "R5 no local cycle", 32'(log_n - b0), 32'h0);
      req(1'b0, a, 4'(be), 32'h0);
      chk(r_ack && !r_retry, "R4 matching repeat acked", {30'd0, r_ack, r_retry}, 32'h2);
      chk(r_rdata == exp_rd(off, 4'(be)), "R8 read data lanes", r_rdata, exp_rd(off, 4'(be)));
      chk(r_lanes == 4'(be), "R8 lanes equal enables", 32'(r_lanes), 32'(be));
    end

    // R9: delivered entry is free, same read starts again
    off = 32'h40 + (32'd15 << 2);
    b0 = log_n;
    req(1'b0, win_base + off, 4'hF, 32'h0);
    chk(r_retry && !r_ack, "R9 re-read starts afresh", {30'd0, r_ack, r_retry}, 32'h1);
    idle(20);
    chk(log_n - b0 == 2, "R9 new local read", 32'(log_n - b0), 32'h2);
    req(1'b0, win_base + off, 4'hF, 32'h0);
    chk(r_ack && r_rdata == exp_rd(off, 4'hF), "R9 re-read data", r_rdata, exp_rd(off, 4'hF));

    // R6: out-of-window requests with a 256-byte window
    for (int i = 0; i < 4; i++) begin
      case (i)
        0: a = win_base - 32'h4;
        1: a = win_base + 32'h100;
        2: a = win_base ^ 32'h8000_0000;
        default: a = win_base + 32'h1000;
      endcase
      for (int w = 0; w < 2; w++) begin
        b0 = log_n;
        req(1'(w), a, 4'hF, 32'h7777_7777);
        chk(!r_ack && !r_retry, "R6 miss silent", {30'd0, r_ack, r_retry}, 32'h0);
        idle(8);
        chk(log_n == b0, "R6 miss no local cycle", 32'(log_n - b0), 32'h0);
      end
    end
    chk(!lb_req, "R6 local bus idle", {31'd0, lb_req}, 32'h0);

    // R6: larger window takes base+0x100, still misses base+0x1000
    win_log2 = 5'd12;
    b0 = log_n;
    req(1'b0, win_base + 32'h100, 4'hF, 32'h0);
    chk(r_retry, "R6 wider window hit", {31'd0, r_retry}, 32'h1);
    idle(20);
    chk_log(b0, 1'b0, 32'h100, 4'hF, 32'h0, "R7 wide offset");
    req(1'b0, win_base + 32'h100, 4'hF, 32'h0);
    chk(r_ack && r_rdata == exp_rd(32'h100, 4'hF), "R4 wide read data", r_rdata, exp_rd(32'h100, 4'hF));
    req(1'b1, win_base + 32'h1000, 4'hF, 32'h0);
    chk(!r_ack && !r_retry, "R6 wider window edge miss", {30'd0, r_ack, r_retry}, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule